// File: doc/BRIEF.md
# Timed Video Write Queue

This block holds a short ring of pending writes to video memory. Each entry records a cycle at which it becomes due, an address, a 16-bit value, a command code and a byte-select kind. At most one entry is retired at each external access slot, and only if the entry at the head has become due. The head entry goes to one of three write ports: a byte-wide video RAM, a 16-bit colour RAM or a 16-bit vertical-scroll RAM.

A host data-port write pushes an entry. Its due time is the present cycle count plus a latency that depends on the horizontal mode. If the push carries the fill-enable command bit while the DMA mode selects fill, the queue also pulses a DMA-run request.

A DMA engine can also reuse the most recently written slot. It rewrites that slot in place and makes it the head again, due at once. This is how copy and fill transfers write bytes without taking a new queue entry.

Top module: `tvwq_top`

## Requirements
- R1: After reset the queue reports empty (`empty_o`=1), not full, and drives no write enable and no DMA request.
- R2: A push taken at cycle count C is due at C+16·LAT when `push_wide_i`=1 and at C+20·LAT otherwise, with LAT=3 by default. The entry is written out only on a slot whose cycle count is at or past its due cycle. The write enable shows in the cycle after that slot.
- R3: The ring takes DEPTH entries (4 by default) and then raises `full_o`. A push made while full is discarded and never reaches any write port.
- R4: Entries leave in push order, one per slot at most. After the last entry is retired, `empty_o` returns to 1 and further slots produce no write.
- R5: A video-RAM entry (command low nibble 4'b0001) of kind 0 takes two slots. The first writes value[15:8] to the address itself. The second writes value[7:0] to the address XOR 1. The entry stays queued between the two.
- R6: A video-RAM entry of kind 2 writes value[15:8] to address XOR 1. Kind 1 or 3 writes value[7:0] to address XOR 1. Each takes one slot.
- R7: A colour-RAM entry (low nibble 4'b0011) writes the full 16-bit value at index (address/2) mod CRAM_DEPTH, with a default depth of 64.
- R8: A scroll-RAM entry (low nibble 4'b0101) uses index (address/2) mod 64. It writes only when that index is below VSRAM_SIZE (40 by default). Otherwise it is retired with no write.
- R9: `dma_req_o` pulses for one cycle after an accepted push whose command bit 5 is 1 while `dma_mode_i` is 2'b10. It stays low for any other mode or command.
- R10: A re-queue request (`rq_i`) made while the queue is empty and no push is present does three things. It rewrites the last-written slot with address `rq_addr_i` and kind `rq_kind_i`, makes the slot due at the present cycle, and turns it into the head. With kind 1 the value keeps bits [15:8], takes `rq_byte_i` as bits [7:0], and the command becomes video RAM. With kind 2 the value and command are kept. A re-queue made while the queue is not empty is ignored.
- R11: An entry with any other command low nibble is retired on its slot with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_i | input | CW | Running cycle count |
| slot_i | input | 1 | External access slot strobe |
| push_i | input | 1 | Data-port write strobe |
| push_wide_i | input | 1 | Wide horizontal mode selects the shorter latency |
| push_addr_i | input | AW | Write address |
| push_data_i | input | 16 | Write value |
| push_cmd_i | input | CMDW | Command code |
| push_kind_i | input | 2 | Byte-select kind |
| dma_mode_i | input | 2 | DMA mode bits (2'b10 = fill) |
| rq_i | input | 1 | Re-queue request from the DMA engine |
| rq_kind_i | input | 2 | Kind for the re-queued entry |
| rq_addr_i | input | AW | Address for the re-queued entry |
| rq_byte_i | input | 8 | Copy byte for kind 1 |
| empty_o | output | 1 | Read index invalid |
| full_o | output | 1 | Ring full |
| dma_req_o | output | 1 | DMA-run request pulse |
| vram_we_o | output | 1 | Video RAM write enable |
| vram_addr_o | output | AW | Video RAM byte address |
| vram_data_o | output | 8 | Video RAM byte |
| cram_we_o | output | 1 | Colour RAM write enable |
| cram_addr_o | output | log2(CRAM_DEPTH) | Colour RAM index |
| cram_data_o | output | 16 | Colour RAM word |
| vsram_we_o | output | 1 | Scroll RAM write enable |
| vsram_addr_o | output | 6 | Scroll RAM index |
| vsram_data_o | output | 16 | Scroll RAM word |

## Verification
A read index that does not match the write index shows up quickly. The next slot either sends out a stale entry or misses a fresh one, and `empty_o` or `full_o` switches on the wrong push or retirement. A wrong due value shows as a write enable one slot too early or too late. A wrong byte lane or a missing XOR shows in `vram_addr_o`/`vram_data_o` in the cycle after the slot. A re-queue that rewrites the wrong slot, or that is accepted when it should be refused, shows at the next slot as the wrong address or byte.

// File: rtl/tvwq_pkg.sv
package tvwq_pkg;
   localparam logic [3:0] CMD_VRAM  = 4'b0001;
   localparam logic [3:0] CMD_CRAM  = 4'b0011;
   localparam logic [3:0] CMD_VSRAM = 4'b0101;

   typedef enum logic [1:0] {
      K_FULL = 2'd0,
      K_LO   = 2'd1,
      K_HI   = 2'd2,
      K_LO3  = 2'd3
   } kind_e;
endpackage

// File: rtl/tvwq_ring.sv
module tvwq_ring
   import tvwq_pkg::*;
#(
   parameter int DEPTH     = 4,
   parameter int AW        = 16,
   parameter int CW        = 32,
   parameter int CMDW      = 6,
   parameter int LAT       = 3,
   parameter bit WRAP_SAFE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CW-1:0]   cycle_i,
   input  logic            push_i,
   input  logic            push_wide_i,
   input  logic [AW-1:0]   push_addr_i,
   input  logic [15:0]     push_data_i,
   input  logic [CMDW-1:0] push_cmd_i,
   input  kind_e           push_kind_i,
   output logic            push_acc_o,
   input  logic            rq_i,
   input  kind_e           rq_kind_i,
   input  logic [AW-1:0]   rq_addr_i,
   input  logic [7:0]      rq_byte_i,
   input  logic            slot_i,
   output logic            fire_o,
   output logic [AW-1:0]   head_addr_o,
   output logic [15:0]     head_data_o,
   output logic [CMDW-1:0] head_cmd_o,
   output kind_e           head_kind_o,
   output logic            empty_o,
   output logic            full_o
);
   localparam int IW = $clog2(DEPTH);
   localparam logic [CW-1:0] DLY_WIDE   = CW'(16 * LAT);
   localparam logic [CW-1:0] DLY_NARROW = CW'(20 * LAT);

   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("tvwq_ring: DEPTH must be a power of two of at least 2");
   end
   if (CMDW < 6) begin : g_bad_cmdw
      $error("tvwq_ring: CMDW must hold at least 6 bits");
   end

   typedef struct packed {
      logic [CW-1:0]   due;
      logic [AW-1:0]   addr;
      logic [15:0]     data;
      logic [CMDW-1:0] cmd;
      kind_e           kind;
   } ent_t;

   ent_t            ent_q [DEPTH];
   logic [IW-1:0]   wr_q, rd_q;
   logic            vld_q;
   ent_t            head;
   logic            due_ok, split, pop, rq_acc;
   logic [IW-1:0]   rd_inc, wr_dec;

   assign head     = ent_q[rd_q];
   assign rd_inc   = rd_q + IW'(1);
   assign wr_dec   = wr_q - IW'(1);
   assign full_o   = vld_q && (wr_q == rd_q);
   assign empty_o  = !vld_q;
   assign push_acc_o = push_i && !full_o;
   assign rq_acc   = rq_i && !vld_q && !push_i;

   if (WRAP_SAFE) begin : g_due_wrap
      logic [CW-1:0] diff;
      assign diff   = cycle_i - head.due;
      assign due_ok = !diff[CW-1];
   end else begin : g_due_plain
      assign due_ok = cycle_i >= head.due;
   end

   assign fire_o = slot_i && vld_q && due_ok;
   assign split  = fire_o && (head.cmd[3:0] == CMD_VRAM) && (head.kind == K_FULL);
   assign pop    = fire_o && !split;

   assign head_addr_o = head.addr;
   assign head_data_o = head.data;
   assign head_cmd_o  = head.cmd;
   assign head_kind_o = head.kind;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         vld_q <= 1'b0;
         for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      end else begin
         if (push_acc_o) begin
            ent_q[wr_q].due  <= cycle_i + (push_wide_i ? DLY_WIDE : DLY_NARROW);
            ent_q[wr_q].addr <= push_addr_i;
            ent_q[wr_q].data <= push_data_i;
            ent_q[wr_q].cmd  <= push_cmd_i;
            ent_q[wr_q].kind <= push_kind_i;
            wr_q <= wr_q + IW'(1);
            if (!vld_q) begin
               rd_q  <= wr_q;
               vld_q <= 1'b1;
            end
         end
         if (rq_acc) begin
            ent_q[wr_dec].due  <= cycle_i;
            ent_q[wr_dec].addr <= rq_addr_i;
            ent_q[wr_dec].kind <= rq_kind_i;
            if (rq_kind_i != K_HI) begin
               ent_q[wr_dec].data[7:0] <= rq_byte_i;
               ent_q[wr_dec].cmd       <= CMDW'(CMD_VRAM);
            end
            rd_q  <= wr_dec;
            vld_q <= 1'b1;
         end
         if (split) begin
            ent_q[rd_q].kind <= K_LO;
         end
         if (pop) begin
            rd_q <= rd_inc;
            if ((rd_inc == wr_q) && !push_acc_o) vld_q <= 1'b0;
         end
      end
   end

   // a push into a full ring leaves the write index where it was
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && push_i) |=> (wr_q == $past(wr_q)));

   // a refused re-queue leaves the read index in place
   p_rq_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rq_i && vld_q && !pop) |=> (rd_q == $past(rd_q)));
endmodule

// File: rtl/tvwq_commit.sv
module tvwq_commit
   import tvwq_pkg::*;
#(
   parameter int AW         = 16,
   parameter int CMDW       = 6,
   parameter int CRAM_DEPTH = 64,
   parameter int VSRAM_SIZE = 40
) (
   input  logic            fire_i,
   input  logic [AW-1:0]   addr_i,
   input  logic [15:0]     data_i,
   input  logic [CMDW-1:0] cmd_i,
   input  kind_e           kind_i,
   output logic            vram_we_o,
   output logic [AW-1:0]   vram_addr_o,
   output logic [7:0]      vram_data_o,
   output logic            cram_we_o,
   output logic [$clog2(CRAM_DEPTH)-1:0] cram_addr_o,
   output logic [15:0]     cram_data_o,
   output logic            vsram_we_o,
   output logic [5:0]      vsram_addr_o,
   output logic [15:0]     vsram_data_o
);
   localparam int CAW = $clog2(CRAM_DEPTH);

   if ((CRAM_DEPTH < 2) || ((CRAM_DEPTH & (CRAM_DEPTH - 1)) != 0) || (CAW >= AW)) begin : g_bad_cram
      $error("tvwq_commit: CRAM_DEPTH must be a power of two that fits the address");
   end
   if ((VSRAM_SIZE < 1) || (VSRAM_SIZE > 64) || (AW < 7)) begin : g_bad_vsram
      $error("tvwq_commit: VSRAM_SIZE must be 1..64 and AW at least 7");
   end

   logic [5:0] vs_idx;
   logic       vs_in;
   logic [AW-1:0] addr_swap;

   assign vs_idx    = addr_i[6:1];
   assign addr_swap = {addr_i[AW-1:1], ~addr_i[0]};

   if (VSRAM_SIZE >= 64) begin : g_vs_all
      assign vs_in = 1'b1;
   end else begin : g_vs_cut
      assign vs_in = vs_idx < 6'(VSRAM_SIZE);
   end

   logic unused_ok;
   assign unused_ok = ^{cmd_i[CMDW-1:4]};

   always_comb begin
      vram_we_o    = 1'b0;
      vram_addr_o  = addr_swap;
      vram_data_o  = data_i[7:0];
      cram_we_o    = 1'b0;
      cram_addr_o  = addr_i[CAW:1];
      cram_data_o  = data_i;
      vsram_we_o   = 1'b0;
      vsram_addr_o = vs_idx;
      vsram_data_o = data_i;
      if (fire_i) begin
         case (cmd_i[3:0])
            CMD_VRAM: begin
               vram_we_o = 1'b1;
               if (kind_i == K_FULL) begin
                  vram_addr_o = addr_i;
                  vram_data_o = data_i[15:8];
               end else if (kind_i == K_HI) begin
                  vram_data_o = data_i[15:8];
               end
            end
            CMD_CRAM:  cram_we_o  = 1'b1;
            CMD_VSRAM: vsram_we_o = vs_in;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/tvwq_top.sv
module tvwq_top
   import tvwq_pkg::*;
#(
   parameter int DEPTH      = 4,
   parameter int AW         = 16,
   parameter int CW         = 32,
   parameter int CMDW       = 6,
   parameter int LAT        = 3,
   parameter int CRAM_DEPTH = 64,
   parameter int VSRAM_SIZE = 40,
   parameter bit WRAP_SAFE  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CW-1:0]   cycle_i,
   input  logic            slot_i,
   input  logic            push_i,
   input  logic            push_wide_i,
   input  logic [AW-1:0]   push_addr_i,
   input  logic [15:0]     push_data_i,
   input  logic [CMDW-1:0] push_cmd_i,
   input  logic [1:0]      push_kind_i,
   input  logic [1:0]      dma_mode_i,
   input  logic            rq_i,
   input  logic [1:0]      rq_kind_i,
   input  logic [AW-1:0]   rq_addr_i,
   input  logic [7:0]      rq_byte_i,
   output logic            empty_o,
   output logic            full_o,
   output logic            dma_req_o,
   output logic            vram_we_o,
   output logic [AW-1:0]   vram_addr_o,
   output logic [7:0]      vram_data_o,
   output logic            cram_we_o,
   output logic [$clog2(CRAM_DEPTH)-1:0] cram_addr_o,
   output logic [15:0]     cram_data_o,
   output logic            vsram_we_o,
   output logic [5:0]      vsram_addr_o,
   output logic [15:0]     vsram_data_o
);
   localparam int CAW = $clog2(CRAM_DEPTH);

   logic            push_acc, fire;
   logic [AW-1:0]   h_addr;
   logic [15:0]     h_data;
   logic [CMDW-1:0] h_cmd;
   kind_e           h_kind;

   logic            vw_d, cw_d, sw_d;
   logic [AW-1:0]   va_d;
   logic [7:0]      vd_d;
   logic [CAW-1:0]  ca_d;
   logic [15:0]     cd_d, sd_d;
   logic [5:0]      sa_d;

   tvwq_ring #(
      .DEPTH(DEPTH), .AW(AW), .CW(CW), .CMDW(CMDW), .LAT(LAT), .WRAP_SAFE(WRAP_SAFE)
   ) u_ring (
      .clk(clk), .rst_n(rst_n), .cycle_i(cycle_i),
      .push_i(push_i), .push_wide_i(push_wide_i), .push_addr_i(push_addr_i),
      .push_data_i(push_data_i), .push_cmd_i(push_cmd_i),
      .push_kind_i(kind_e'(push_kind_i)), .push_acc_o(push_acc),
      .rq_i(rq_i), .rq_kind_i(kind_e'(rq_kind_i)), .rq_addr_i(rq_addr_i),
      .rq_byte_i(rq_byte_i), .slot_i(slot_i), .fire_o(fire),
      .head_addr_o(h_addr), .head_data_o(h_data), .head_cmd_o(h_cmd),
      .head_kind_o(h_kind), .empty_o(empty_o), .full_o(full_o)
   );

   tvwq_commit #(
      .AW(AW), .CMDW(CMDW), .CRAM_DEPTH(CRAM_DEPTH), .VSRAM_SIZE(VSRAM_SIZE)
   ) u_commit (
      .fire_i(fire), .addr_i(h_addr), .data_i(h_data), .cmd_i(h_cmd), .kind_i(h_kind),
      .vram_we_o(vw_d), .vram_addr_o(va_d), .vram_data_o(vd_d),
      .cram_we_o(cw_d), .cram_addr_o(ca_d), .cram_data_o(cd_d),
      .vsram_we_o(sw_d), .vsram_addr_o(sa_d), .vsram_data_o(sd_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dma_req_o    <= 1'b0;
         vram_we_o    <= 1'b0;
         vram_addr_o  <= '0;
         vram_data_o  <= '0;
         cram_we_o    <= 1'b0;
         cram_addr_o  <= '0;
         cram_data_o  <= '0;
         vsram_we_o   <= 1'b0;
         vsram_addr_o <= '0;
         vsram_data_o <= '0;
      end else begin
         dma_req_o    <= push_acc && push_cmd_i[5] && (dma_mode_i == 2'b10);
         vram_we_o    <= vw_d;
         vram_addr_o  <= va_d;
         vram_data_o  <= vd_d;
         cram_we_o    <= cw_d;
         cram_addr_o  <= ca_d;
         cram_data_o  <= cd_d;
         vsram_we_o   <= sw_d;
         vsram_addr_o <= sa_d;
         vsram_data_o <= sd_d;
      end
   end

   p_one_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({vram_we_o, cram_we_o, vsram_we_o}));

   p_write_after_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (vram_we_o || cram_we_o || vsram_we_o) |-> $past(slot_i));

   p_vsram_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      vsram_we_o |-> ({1'b0, vsram_addr_o} < 7'(VSRAM_SIZE)));

   p_dma_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req_o |-> $past(push_i && push_cmd_i[5] && (dma_mode_i == 2'b10)));

   p_empty_not_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      empty_o |-> !full_o);
endmodule

// File: tb/sim_tvwq_top.sv
module sim_tvwq_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cyc = '0;
   logic        slot = 1'b0, push = 1'b0, wide = 1'b0, rq = 1'b0;
   logic [15:0] paddr = '0, pdata = '0, rqaddr = '0;
   logic [5:0]  pcmd = '0;
   logic [1:0]  pkind = '0, mode = '0, rqkind = '0;
   logic [7:0]  rqbyte = '0;
   logic        empty, full, dreq, vwe, cwe, swe;
   logic [15:0] vaddr, cdata, sdata;
   logic [7:0]  vdata;
   logic [5:0]  caddr, saddr;
   int          n_chk = 0, n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tvwq_top u0 (
      .clk(clk), .rst_n(rst_n), .cycle_i(cyc), .slot_i(slot),
      .push_i(push), .push_wide_i(wide), .push_addr_i(paddr), .push_data_i(pdata),
      .push_cmd_i(pcmd), .push_kind_i(pkind), .dma_mode_i(mode),
      .rq_i(rq), .rq_kind_i(rqkind), .rq_addr_i(rqaddr), .rq_byte_i(rqbyte),
      .empty_o(empty), .full_o(full), .dma_req_o(dreq),
      .vram_we_o(vwe), .vram_addr_o(vaddr), .vram_data_o(vdata),
      .cram_we_o(cwe), .cram_addr_o(caddr), .cram_data_o(cdata),
      .vsram_we_o(swe), .vsram_addr_o(saddr), .vsram_data_o(sdata)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_push(input logic [15:0] a, input logic [15:0] d, input logic [5:0] c,
                          input logic [1:0] k, input logic w);
      paddr = a; pdata = d; pcmd = c; pkind = k; wide = w; push = 1'b1;
      tick();
      push = 1'b0;
   endtask

   task automatic do_slot();
      slot = 1'b1;
      tick();
      slot = 1'b0;
   endtask

   task automatic do_rq(input logic [15:0] a, input logic [1:0] k, input logic [7:0] b);
      rqaddr = a; rqkind = k; rqbyte = b; rq = 1'b1;
      tick();
      rq = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "empty", empty, 1);
      chk("R1", "full", full, 0);
      chk("R1", "writes", {vwe, cwe, swe, dreq}, 0);
   endtask

   task automatic t_due();
      cyc = 100;
      do_push(16'h0040, 16'h0012, 6'h01, 2'd1, 1'b1);
      cyc = 147; do_slot();
      chk("R2", "early wide slot", vwe, 0);
      cyc = 148; do_slot();
      chk("R2", "wide due write", vwe, 1);
      chk("R6", "kind1 addr", vaddr, 16'h0041);
      chk("R6", "kind1 byte", vdata, 8'h12);
      chk("R4", "empty after last", empty, 1);
      cyc = 200;
      do_push(16'h0050, 16'h3400, 6'h01, 2'd2, 1'b0);
      cyc = 259; do_slot();
      chk("R2", "early narrow slot", vwe, 0);
      cyc = 260; do_slot();
      chk("R2", "narrow due write", vwe, 1);
      chk("R6", "kind2 addr", vaddr, 16'h0051);
      chk("R6", "kind2 byte", vdata, 8'h34);
   endtask

   task automatic t_full();
      cyc = 0;
      for (int i = 0; i < 5; i++) begin
         do_push(16'(16'h0080 + 2*i), 16'(i + 1), 6'h01, 2'd1, 1'b1);
         if (i == 2) chk("R3", "not full at 3", full, 0);
      end
      chk("R3", "full at 4", full, 1);
      cyc = 1000;
      for (int i = 0; i < 4; i++) begin
         do_slot();
         chk("R4", "order addr", vaddr, 32'(16'h0081 + 2*i));
         chk("R4", "order data", vdata, 32'(i + 1));
      end
      chk("R4", "empty after drain", empty, 1);
      do_slot();
      chk("R3", "dropped push absent", vwe, 0);
   endtask

   task automatic t_split();
      cyc = 0;
      do_push(16'h0010, 16'hABCD, 6'h01, 2'd0, 1'b0);
      cyc = 60; do_slot();
      chk("R5", "first addr", vaddr, 16'h0010);
      chk("R5", "first byte", vdata, 8'hAB);
      chk("R5", "still queued", empty, 0);
      do_slot();
      chk("R5", "second addr", vaddr, 16'h0011);
      chk("R5", "second byte", vdata, 8'hCD);
      chk("R5", "empty after pair", empty, 1);
   endtask

   task automatic t_cram_vsram();
      cyc = 0;
      do_push(16'h0086, 16'h0EEE, 6'h03, 2'd0, 1'b1);
      do_push(16'h004E, 16'h1234, 6'h05, 2'd0, 1'b1);
      do_push(16'h0050, 16'h5678, 6'h05, 2'd0, 1'b1);
      do_push(16'h008E, 16'h9ABC, 6'h05, 2'd0, 1'b1);
      cyc = 500;
      do_slot();
      chk("R7", "cram we", cwe, 1);
      chk("R7", "cram index", caddr, 6'd3);
      chk("R7", "cram word", cdata, 16'h0EEE);
      do_slot();
      chk("R8", "vsram top index", {swe, saddr}, {1'b1, 6'd39});
      chk("R8", "vsram word", sdata, 16'h1234);
      do_slot();
      chk("R8", "out of range dropped", {vwe, cwe, swe}, 0);
      do_slot();
      chk("R8", "index wraps mod 64", {swe, saddr}, {1'b1, 6'd7});
      chk("R8", "empty", empty, 1);
      do_push(16'h0020, 16'h1111, 6'h02, 2'd0, 1'b1);
      cyc = 600; do_slot();
      chk("R11", "unknown command no write", {vwe, cwe, swe}, 0);
      chk("R11", "unknown command retired", empty, 1);
   endtask

   task automatic t_dma();
      cyc = 0;
      mode = 2'b10;
      do_push(16'h0000, 16'h0000, 6'h21, 2'd1, 1'b1);
      chk("R9", "fill request", dreq, 1);
      tick();
      chk("R9", "request one cycle", dreq, 0);
      mode = 2'b01;
      do_push(16'h0002, 16'h0000, 6'h21, 2'd1, 1'b1);
      chk("R9", "other mode", dreq, 0);
      mode = 2'b10;
      do_push(16'h0004, 16'h0000, 6'h01, 2'd1, 1'b1);
      chk("R9", "bit 5 clear", dreq, 0);
      mode = 2'b00;
      cyc = 100;
      for (int i = 0; i < 3; i++) do_slot();
      chk("R4", "drained", empty, 1);
   endtask

   task automatic t_requeue();
      cyc = 0;
      do_push(16'h0010, 16'hAB00, 6'h01, 2'd1, 1'b0);
      cyc = 60; do_slot();
      chk("R10", "setup write", vaddr, 16'h0011);
      do_rq(16'h0020, 2'd1, 8'h5E);
      chk("R10", "re-queued not empty", empty, 0);
      do_slot();
      chk("R10", "copy addr", {vwe, vaddr}, {1'b1, 16'h0021});
      chk("R10", "copy byte", vdata, 8'h5E);
      do_rq(16'h0030, 2'd2, 8'h00);
      do_slot();
      chk("R10", "fill addr", {vwe, vaddr}, {1'b1, 16'h0031});
      chk("R10", "fill keeps upper byte", vdata, 8'hAB);
      do_push(16'h0060, 16'h0077, 6'h01, 2'd1, 1'b0);
      do_rq(16'h0070, 2'd1, 8'h99);
      cyc = 120; do_slot();
      chk("R10", "busy re-queue ignored addr", vaddr, 16'h0061);
      chk("R10", "busy re-queue ignored byte", vdata, 8'h77);
      chk("R10", "empty after", empty, 1);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_due();
      t_full();
      t_split();
      t_cram_vsram();
      t_dma();
      t_requeue();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule